// File: doc/BRIEF.md
# Two-Level DMA Descriptor Chain Walker

This block steers a DMA transfer engine through a chain in memory that has two levels. The outer level links list descriptors. Each list descriptor names the head of an inner chain of link descriptors, and each link descriptor describes one transfer. Software loads a 36-bit start address, given as a 32-bit base and a 4-bit extension, and pulses start. The walker then reads descriptor words one at a time over a simple request/valid read port. It hands each transfer's source, destination and length to an external engine and waits for that engine's done pulse. After each transfer it decides whether to follow the link chain, move on to the next list, or stop.

Every descriptor is 32-byte aligned. Because of this alignment, the low five bits of a pointer word are free to carry the 4-bit address extension and one flag. Interrupts can be raised for each segment, and sticky complete and error flags report how the walk ended. In direct mode the walker skips the descriptor memory and runs a single transfer taken from its input pins.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset, busy_o, done_o, err_o, mem_req_o, xfer_start_o and seg_irq_o are all 0.
- R2: A start in chain mode loads cur_list_o with {list_ext_i, list_base_i}. The walker then reads the two words of the list descriptor at that address A, first A and then A+4. Word 0 holds the first-link pointer. Word 1 holds the next-list pointer, with its end-of-lists flag in bit 0. Every pointer word decodes to the address {w[4:1], w[31:5], 5'b0}.
- R3: A link descriptor is four words, read at offsets 0, 4, 8 and 12: the source, the destination, {irq_enable[31], length[30:0]}, and the next-link pointer with its end-of-links flag in bit 0. Source and destination are zero-extended to 36 bits. xfer_start_o pulses for exactly one cycle with these values, and the walker waits for xfer_done_i.
- R4: After a transfer whose end-of-links flag is 0, the walker fetches the next link from that link's next-link pointer.
- R5: After a transfer whose end-of-links flag is 1, the next-list pointer is copied into cur_list_o. If the end-of-lists flag is 0, the new list descriptor is fetched and its links are processed.
- R6: When the last link finishes and the end-of-lists flag is 1, busy_o drops and done_o is set. done_o then stays set until it is cleared.
- R7: seg_irq_o pulses for one cycle in the cycle after xfer_done_i if the link's irq_enable bit is 1. It does not pulse if the bit is 0.
- R8: With chain_mode_i = 0 at start, the walker runs one transfer from dir_src_i, dir_dst_i and dir_len_i. It issues no memory reads, raises no seg_irq_o, and then sets done_o. The end-of-links flag plays no part in this mode.
- R9: start_i has no effect while busy_o is 1.
- R10: clr_status_i clears done_o and err_o.
- R11: A read response with mem_err_i = 1 ends the walk. err_o is set, busy_o drops, no further transfer starts and done_o stays 0.
- R12: Each descriptor word is fetched with one handshake. mem_req_o stays high and mem_addr_o stays stable until mem_valid_i arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| chain_mode_i | input | 1 | 1 = walk the descriptor chain, 0 = single direct transfer |
| list_base_i | input | 32 | Low 32 bits of the first list descriptor address |
| list_ext_i | input | 4 | Upper 4 bits of the first list descriptor address |
| dir_src_i | input | 36 | Direct-mode source address |
| dir_dst_i | input | 36 | Direct-mode destination address |
| dir_len_i | input | 31 | Direct-mode byte count |
| clr_status_i | input | 1 | Clears the sticky done and error flags |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 36 | Descriptor word address |
| mem_valid_i | input | 1 | Read response valid |
| mem_err_i | input | 1 | Read response carries an error |
| mem_rdata_i | input | 32 | Read data |
| xfer_start_o | output | 1 | One-cycle transfer start pulse |
| xfer_src_o | output | 36 | Transfer source |
| xfer_dst_o | output | 36 | Transfer destination |
| xfer_len_o | output | 31 | Transfer byte count |
| xfer_done_i | input | 1 | Transfer engine done pulse |
| seg_irq_o | output | 1 | End-of-segment interrupt pulse |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Sticky run-complete flag |
| err_o | output | 1 | Sticky read-error flag |
| cur_list_o | output | 36 | Current list descriptor address register |

## Verification
The assertions check the following on every cycle: the request address holds steady while a read is waiting; the start pulse lasts one cycle; an interrupt comes only directly after a done pulse; an error response aborts the walk at once; the done flag stays set until cleared; a start taken in the middle of a transfer leaves the current list register unchanged. Other behaviour only the bench scenarios can show, because it depends on the descriptor contents. That includes the order in which lists and links are visited, the decoding of the 36-bit pointers and their flags, the final value of the current list register, and the exact number of interrupts and transfers per run. The bench covers this with random chains of one to three lists and one to three links each, in direct mode, and with an injected read error.

// File: rtl/dma_walk_pkg.sv
package dma_walk_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned EXT_W   = 4;
  localparam int unsigned AW      = DW + EXT_W;
  localparam int unsigned ALIGN_W = EXT_W + 1;   // ext bits + one flag
  localparam int unsigned LEN_W   = DW - 1;
  localparam int unsigned IDX_W   = 2;

  localparam logic [IDX_W-1:0] LIST_LAST = IDX_W'(1);
  localparam logic [IDX_W-1:0] LINK_LAST = IDX_W'(3);
  localparam logic [IDX_W-1:0] W_SRC = 2'd0, W_DST = 2'd1, W_CNT = 2'd2, W_NXT = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_LIST, ST_FETCH_LINK, ST_XFER, ST_ADVANCE, ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic [AW-1:0]    src;
    logic [AW-1:0]    dst;
    logic [LEN_W-1:0] len;
    logic             ie;
    logic [AW-1:0]    nxt;
    logic             eol;
  } link_desc_t;

  function automatic logic [AW-1:0] ptr_decode(input logic [DW-1:0] w);
    return {w[EXT_W:1], w[DW-1:ALIGN_W], {ALIGN_W{1'b0}}};
  endfunction
endpackage

// File: rtl/dma_desc_reader.sv
module dma_desc_reader
  import dma_walk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_valid_i,
  input  logic             mem_err_i,
  output logic             word_stb_o,
  output logic [IDX_W-1:0] word_idx_o,
  output logic             word_last_o,
  output logic             rd_err_o
);
  logic [IDX_W-1:0] idx_q;

  assign mem_req_o   = active_i;
  assign mem_addr_o  = base_i + AW'({idx_q, 2'b00});
  assign word_stb_o  = active_i & mem_valid_i & ~mem_err_i;
  assign rd_err_o    = active_i & mem_valid_i & mem_err_i;
  assign word_idx_o  = idx_q;
  assign word_last_o = word_stb_o && (idx_q == last_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  idx_q <= '0;
    else if (!active_i || rd_err_o || word_last_o) idx_q <= '0;
    else if (word_stb_o)                          idx_q <= idx_q + 1'b1;
  end

  p_addr_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)))
    else $error("request address moved while waiting");
endmodule

// File: rtl/dma_link_regs.sv
module dma_link_regs
  import dma_walk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_dir_i,
  input  logic [AW-1:0]    dir_src_i,
  input  logic [AW-1:0]    dir_dst_i,
  input  logic [LEN_W-1:0] dir_len_i,
  input  logic             stb_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    word_i,
  output link_desc_t       link_o
);
  link_desc_t link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= '0;
    end else if (load_dir_i) begin
      // eol left clear: direct mode must finish regardless of it
      link_q <= '{src: dir_src_i, dst: dir_dst_i, len: dir_len_i,
                  ie: 1'b0, nxt: '0, eol: 1'b0};
    end else if (stb_i) begin
      unique case (idx_i)
        W_SRC: link_q.src <= AW'(word_i);
        W_DST: link_q.dst <= AW'(word_i);
        W_CNT: {link_q.ie, link_q.len} <= word_i;
        default: begin
          link_q.nxt <= ptr_decode(word_i);
          link_q.eol <= word_i[0];
        end
      endcase
    end
  end

  assign link_o = link_q;
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
  import dma_walk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             chain_mode_i,
  input  logic [DW-1:0]    list_base_i,
  input  logic [EXT_W-1:0] list_ext_i,
  input  logic [AW-1:0]    dir_src_i,
  input  logic [AW-1:0]    dir_dst_i,
  input  logic [LEN_W-1:0] dir_len_i,
  input  logic             clr_status_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_valid_i,
  input  logic             mem_err_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             xfer_start_o,
  output logic [AW-1:0]    xfer_src_o,
  output logic [AW-1:0]    xfer_dst_o,
  output logic [LEN_W-1:0] xfer_len_o,
  input  logic             xfer_done_i,
  output logic             seg_irq_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [AW-1:0]    cur_list_o
);
  walk_state_e      state_q;
  logic             chain_q, issued_q, eolsd_q, done_q, err_q;
  logic [AW-1:0]    cur_list_q, nxt_list_q, cur_link_q;
  logic             rd_active, word_stb, word_last, rd_err, load_dir;
  logic [IDX_W-1:0] word_idx;
  link_desc_t       link;

  assign rd_active = (state_q == ST_FETCH_LIST) || (state_q == ST_FETCH_LINK);
  assign load_dir  = (state_q == ST_IDLE) && start_i && !chain_mode_i;

  dma_desc_reader i_reader (
    .clk_i, .rst_ni,
    .active_i   (rd_active),
    .base_i     ((state_q == ST_FETCH_LIST) ? cur_list_q : cur_link_q),
    .last_idx_i ((state_q == ST_FETCH_LIST) ? LIST_LAST : LINK_LAST),
    .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_err_i,
    .word_stb_o (word_stb),
    .word_idx_o (word_idx),
    .word_last_o(word_last),
    .rd_err_o   (rd_err)
  );

  dma_link_regs i_link (
    .clk_i, .rst_ni,
    .load_dir_i (load_dir),
    .dir_src_i, .dir_dst_i, .dir_len_i,
    .stb_i      (word_stb && state_q == ST_FETCH_LINK),
    .idx_i      (word_idx),
    .word_i     (mem_rdata_i),
    .link_o     (link)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      chain_q    <= 1'b0;
      issued_q   <= 1'b0;
      eolsd_q    <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      cur_list_q <= '0;
      nxt_list_q <= '0;
      cur_link_q <= '0;
    end else begin
      issued_q <= (state_q == ST_XFER) && !xfer_done_i;
      if (clr_status_i) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          chain_q <= chain_mode_i;
          if (chain_mode_i) begin
            cur_list_q <= {list_ext_i, list_base_i};
            state_q    <= ST_FETCH_LIST;
          end else begin
            state_q    <= ST_XFER;
          end
        end
        ST_FETCH_LIST: begin
          if (word_stb && word_idx == '0) cur_link_q <= ptr_decode(mem_rdata_i);
          if (word_stb && word_idx == LIST_LAST) begin
            nxt_list_q <= ptr_decode(mem_rdata_i);
            eolsd_q    <= mem_rdata_i[0];
          end
          if (rd_err) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (word_last) state_q <= ST_FETCH_LINK;
        end
        ST_FETCH_LINK: begin
          if (rd_err) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (word_last) state_q <= ST_XFER;
        end
        ST_XFER: if (xfer_done_i) state_q <= ST_ADVANCE;
        ST_ADVANCE: begin
          if (!chain_q) begin
            state_q <= ST_DONE;
          end else if (!link.eol) begin
            cur_link_q <= link.nxt;
            state_q    <= ST_FETCH_LINK;
          end else begin
            cur_list_q <= nxt_list_q;
            state_q    <= eolsd_q ? ST_DONE : ST_FETCH_LIST;
          end
        end
        ST_DONE: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xfer_start_o = (state_q == ST_XFER) && !issued_q;
  assign xfer_src_o   = link.src;
  assign xfer_dst_o   = link.dst;
  assign xfer_len_o   = link.len;
  assign seg_irq_o    = (state_q == ST_ADVANCE) && chain_q && link.ie;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign cur_list_o   = cur_list_q;

  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o) else $error("start pulse too long");
  p_irq_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_irq_o |-> $past(xfer_done_i)) else $error("irq without done");
  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_status_i) |=> done_o) else $error("done dropped");
  p_err_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i && mem_err_i) |=> (!busy_o && err_o))
    else $error("error did not abort");
  p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && start_i) |=> $stable(cur_list_q))
    else $error("start taken while busy");
  p_direct_no_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !chain_q && state_q != ST_IDLE) |-> !mem_req_o)
    else $error("read issued in direct mode");
endmodule

// File: tb/test_dma_chain_walker.sv
`timescale 1ns/1ps
module test_dma_chain_walker;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, chain_mode = 0, clr = 0;
  logic [31:0] list_base = 0;
  logic [3:0]  list_ext = 0;
  logic [35:0] dir_src = 0, dir_dst = 0;
  logic [30:0] dir_len = 0;
  logic        mem_req, mem_valid = 0, mem_err = 0;
  logic [35:0] mem_addr;
  logic [31:0] mem_rdata = 0;
  logic        xfer_start, xfer_done = 0, seg_irq, busy, done, err;
  logic [35:0] xfer_src, xfer_dst, cur_list;
  logic [30:0] xfer_len;

  always #2 clk = ~clk;

  dma_chain_walker i_dma_chain_walker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chain_mode_i(chain_mode),
    .list_base_i(list_base), .list_ext_i(list_ext), .dir_src_i(dir_src),
    .dir_dst_i(dir_dst), .dir_len_i(dir_len), .clr_status_i(clr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid),
    .mem_err_i(mem_err), .mem_rdata_i(mem_rdata), .xfer_start_o(xfer_start),
    .xfer_src_o(xfer_src), .xfer_dst_o(xfer_dst), .xfer_len_o(xfer_len),
    .xfer_done_i(xfer_done), .seg_irq_o(seg_irq), .busy_o(busy), .done_o(done),
    .err_o(err), .cur_list_o(cur_list));

  int checks = 0, errors = 0;
  logic [31:0] mem [logic [35:0]];
  logic [35:0] exp_src [16], exp_dst [16];
  logic [30:0] exp_len [16];
  bit          exp_ie [16];
  int          exp_n = 0, ie_total = 0, xfer_seen = 0, irq_cnt = 0, req_cnt = 0;
  int          slot = 0, cycles = 0;
  logic [35:0] first_list, term_list, first_link, err_addr = '1;
  bit          err_en = 0, cur_ie = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] new_addr();
    slot++;
    return {4'($urandom % 16), 32'h0010_0000 + 32'(slot * 64)};
  endfunction

  function automatic logic [31:0] enc(input logic [35:0] a, input bit f);
    return {a[31:5], a[35:32], f};
  endfunction

  // memory model: one response per request, random latency
  bit waiting = 0; int lat = 0; logic [35:0] wait_addr;
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 0; mem_err = 0; waiting = 0;
    end else if (mem_req) begin
      if (!waiting) begin
        waiting = 1; lat = $urandom % 3; wait_addr = mem_addr; req_cnt++;
        chk(mem.exists(mem_addr), "R2", "read of unknown address", 64'(mem_addr), 64'(mem_addr));
      end else begin
        chk(mem_addr == wait_addr, "R12", "address moved while waiting", 64'(mem_addr), 64'(wait_addr));
      end
      if (lat == 0) begin
        mem_valid = 1;
        mem_err   = err_en && (mem_addr == err_addr);
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'hDEAD_BEEF;
      end else lat--;
    end
  end

  // transfer engine model
  int xcnt = 0;
  always @(negedge clk) begin
    if (xfer_done) begin
      xfer_done = 0;
      chk(seg_irq == cur_ie, "R7", "irq after done", 64'(seg_irq), 64'(cur_ie));
    end else if (xcnt > 0) begin
      xcnt--;
      if (xcnt == 0) xfer_done = 1;
    end else if (xfer_start) begin
      if (xfer_seen >= exp_n) chk(0, "R4", "extra transfer", 64'(xfer_seen), 64'(exp_n));
      else begin
        chk(xfer_src == exp_src[xfer_seen], "R3", "src", 64'(xfer_src), 64'(exp_src[xfer_seen]));
        chk(xfer_dst == exp_dst[xfer_seen], "R3", "dst", 64'(xfer_dst), 64'(exp_dst[xfer_seen]));
        chk(xfer_len == exp_len[xfer_seen], "R3", "len", 64'(xfer_len), 64'(exp_len[xfer_seen]));
        cur_ie = exp_ie[xfer_seen];
      end
      xfer_seen++;
      xcnt = 1 + $urandom % 4;
    end
  end

  always @(negedge clk) if (seg_irq) irq_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic build_chain(input int nlists);
    logic [35:0] la [4];
    logic [35:0] ka [4];
    mem.delete();
    exp_n = 0; ie_total = 0;
    for (int l = 0; l < nlists; l++) la[l] = new_addr();
    term_list = new_addr();
    first_list = la[0];
    for (int l = 0; l < nlists; l++) begin
      int nk = 1 + $urandom % 3;
      for (int k = 0; k < nk; k++) ka[k] = new_addr();
      if (l == 0) first_link = ka[0];
      mem[la[l]]     = enc(ka[0], 1'b0);
      mem[la[l] + 4] = (l == nlists - 1) ? enc(term_list, 1'b1) : enc(la[l+1], 1'b0);
      for (int k = 0; k < nk; k++) begin
        logic [31:0] s = $urandom, d = $urandom;
        logic [30:0] n = 31'($urandom % 4096 + 1);
        bit ie = 1'($urandom % 2);
        mem[ka[k]]      = s;
        mem[ka[k] + 4]  = d;
        mem[ka[k] + 8]  = {ie, n};
        mem[ka[k] + 12] = (k == nk - 1) ? enc(new_addr(), 1'b1) : enc(ka[k+1], 1'b0);
        exp_src[exp_n] = {4'h0, s}; exp_dst[exp_n] = {4'h0, d};
        exp_len[exp_n] = n; exp_ie[exp_n] = ie;
        ie_total += int'(ie); exp_n++;
      end
    end
  endtask

  task automatic clear_status();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic run(input bit mode, input bit poke_start);
    int n = 0;
    xfer_seen = 0; irq_cnt = 0; req_cnt = 0;
    @(negedge clk);
    chain_mode = mode; list_base = first_list[31:0]; list_ext = first_list[35:32];
    start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1, "R2", "busy after start", 64'(busy), 64'd1);
    if (mode) chk(cur_list == first_list, "R2", "current list loaded", 64'(cur_list), 64'(first_list));
    while (!(done || err) && n < 5000) begin
      @(negedge clk); n++;
      if (poke_start && xfer_seen == 1 && n % 7 == 0) begin
        start = 1; chain_mode = ~mode; list_base = 32'h0000_0040; list_ext = 4'h3;
      end else start = 0;
    end
    start = 0;
    chk(n < 5000, "R6", "walk finished", 64'(n), 64'd5000);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err, "R1", "status after reset", {busy, done, err}, 0);
    chk(!mem_req && !xfer_start && !seg_irq, "R1", "outputs after reset",
        {mem_req, xfer_start, seg_irq}, 0);
    rst_n = 1;
    @(negedge clk);

    // random chains, plain and with a start poked mid-run (R9)
    for (int r = 0; r < 8; r++) begin
      build_chain(1 + r % 3);
      clear_status();
      run(1'b1, r == 3 || r == 6);
      chk(xfer_seen == exp_n, "R4", "transfer count", 64'(xfer_seen), 64'(exp_n));
      chk(irq_cnt == ie_total, "R7", "irq count", 64'(irq_cnt), 64'(ie_total));
      chk(done && !busy && !err, "R6", "run complete", {done, busy, err}, 3'b100);
      chk(cur_list == term_list, "R5", "final current list", 64'(cur_list), 64'(term_list));
      if (r == 3 || r == 6)
        chk(xfer_seen == exp_n, "R9", "start while busy ignored", 64'(xfer_seen), 64'(exp_n));
      repeat (4) @(negedge clk);
      chk(done == 1, "R6", "done sticky", 64'(done), 64'd1);
    end

    // R10 clear
    clear_status();
    chk(!done && !err, "R10", "flags cleared", {done, err}, 0);

    // R8 direct mode
    mem.delete();
    exp_n = 1; ie_total = 0;
    dir_src = 36'hA_1234_5678; dir_dst = 36'h5_8765_4320; dir_len = 31'h7FFF_FFFF;
    exp_src[0] = dir_src; exp_dst[0] = dir_dst; exp_len[0] = dir_len; exp_ie[0] = 0;
    first_list = 36'h0_0000_0000;
    run(1'b0, 1'b0);
    chk(req_cnt == 0, "R8", "no reads in direct mode", 64'(req_cnt), 0);
    chk(xfer_seen == 1, "R8", "one transfer", 64'(xfer_seen), 1);
    chk(irq_cnt == 0, "R8", "no irq in direct mode", 64'(irq_cnt), 0);
    chk(done && !busy, "R8", "direct done", {done, busy}, 2'b10);

    // R11 read error on the first link's length word
    clear_status();
    build_chain(2);
    err_addr = first_link + 8; err_en = 1;
    run(1'b1, 1'b0);
    err_en = 0;
    chk(err && !busy && !done, "R11", "abort status", {err, busy, done}, 3'b100);
    chk(xfer_seen == 0, "R11", "no transfer after error", 64'(xfer_seen), 0);
    clear_status();
    chk(!err, "R10", "error cleared", 64'(err), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule